// File: doc/BRIEF.md
# Event blanking window filter

This block screens a digital event, typically the output of an analog comparator, through a blanking window that is timed from the PWM time base. A reference pulse starts the window. The pulse is chosen between the counter-at-zero strobe and the counter-at-period strobe. A programmable delay separates the reference pulse from the window start, and a programmable count sets how long the window stays open. Rising edges of the event that fall inside the window are suppressed. Rising edges that get through become a one-clock filtered pulse, which can also be issued as a sync request that reloads the time-base counter from its phase value.

The block models a fixed three-clock latency between the programmed start of the window and the point where the window actually blanks. Because of this latency, an event that arrives just after a reference pulse can escape blanking. Integrators compensate by placing the window earlier, and a window whose delay runs past the end of the PWM period simply continues into the next period.

Top module: `blank_window_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `win_o`, `evt_o` and `sync_o` are low, and the latency pipeline holds no open-window state.
- R2: `ref_sel_i` = 0 makes `ref_zero_i` the reference pulse and `ref_per_i` is ignored; `ref_sel_i` = 1 does the opposite.
- R3: When a reference pulse is sampled on clock edge r, with delay D = `offset_i` and length L = `length_i` captured on that edge, `win_o` is high after edges r+D+3 through r+D+L+2, so it is high for L clocks.
- R4: The window takes effect three clocks after its programmed start. A rising edge sampled on edges r+D+1 to r+D+3 is therefore not blanked.
- R5: `event_i` is a level. A rising edge sampled on edge n (high on edge n, low on edge n-1) produces `evt_o` high for exactly one clock after edge n, even if the level stays high.
- R6: With `blank_en_i` = 1 and `blank_inv_i` = 0, a rising edge is suppressed if `win_o` is high when that edge is sampled.
- R7: With `blank_en_i` = 1 and `blank_inv_i` = 1, a rising edge is suppressed if `win_o` is low when that edge is sampled.
- R8: With `blank_en_i` = 0, every rising edge reaches `evt_o`.
- R9: `sync_o` pulses in the same cycle as `evt_o` when `sync_en_i` was high on the sampling edge, and it stays low otherwise.
- R10: A new reference pulse that arrives while a window is still delaying or open restarts both counts from the newly captured values.
- R11: With `length_i` = 0, no window opens, and in non-inverted mode nothing is blanked.
- R12: The delay and length counts do not depend on the PWM period. The unselected strobe has no effect, so a window can span a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_zero_i | input | 1 | Counter-at-zero strobe |
| ref_per_i | input | 1 | Counter-at-period strobe |
| ref_sel_i | input | 1 | Reference select: 0 = zero strobe, 1 = period strobe |
| blank_en_i | input | 1 | Blanking enable |
| blank_inv_i | input | 1 | Invert: pass events only while the window is open |
| sync_en_i | input | 1 | Allow filtered events to issue a sync request |
| offset_i | input | OFS_W | Delay from reference pulse to window start, in clocks |
| length_i | input | LEN_W | Window length, in clocks |
| event_i | input | 1 | Event level, for example a comparator trip |
| evt_o | output | 1 | Filtered event pulse |
| sync_o | output | 1 | Sync request pulse (counter reload from phase) |
| win_o | output | 1 | Effective blanking window, after the latency |

## Verification
On every cycle, the assertions check four things: a filtered pulse is never longer than one clock, a sync request never appears without the enable, no pulse escapes while a non-inverted enabled window is effective, and a zero-delay zero-length reference never opens the window. Other behaviours need the bench's scenarios and its cycle-accurate model. These are the exact placement of the window after the three-clock latency, the race in which events just after the programmed start leak through, inversion, restart on a second reference, and a window that spans the unselected strobe.

// File: rtl/bwf_pkg.sv
package bwf_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,
    TMR_WAIT = 2'd1,
    TMR_OPEN = 2'd2
  } tmr_state_t;

  localparam int unsigned WIN_LATENCY = 3;
endpackage

// File: rtl/bwf_win_timer.sv
module bwf_win_timer
  import bwf_pkg::*;
#(
  parameter int unsigned OFS_W = 16,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [LEN_W-1:0] length_i,
  output logic             raw_o
);
  localparam int unsigned CNT_W = (OFS_W > LEN_W) ? OFS_W : LEN_W;

  tmr_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TMR_IDLE;
      cnt   <= '0;
      len_q <= '0;
    end else if (ref_i) begin
      len_q <= length_i;
      if (offset_i != '0) begin
        state <= TMR_WAIT;
        cnt   <= CNT_W'(offset_i);
      end else if (length_i != '0) begin
        state <= TMR_OPEN;
        cnt   <= CNT_W'(length_i);
      end else begin
        state <= TMR_IDLE;
        cnt   <= '0;
      end
    end else begin
      case (state)
        TMR_WAIT: begin
          if (cnt == CNT_W'(1)) begin
            if (len_q != '0) begin
              state <= TMR_OPEN;
              cnt   <= CNT_W'(len_q);
            end else begin
              state <= TMR_IDLE;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        TMR_OPEN: begin
          if (cnt == CNT_W'(1)) begin
            state <= TMR_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          state <= TMR_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign raw_o = (state == TMR_OPEN);

  // R11: zero delay with zero length never opens the window
  p_zero_len_r11: assert property (@(posedge clk) disable iff (rst)
    (ref_i && offset_i == '0 && length_i == '0) |=> !raw_o);

  // R10: a reference with a nonzero delay restarts into the delay phase
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (ref_i && offset_i != '0) |=> !raw_o);
endmodule

// File: rtl/bwf_latency_pipe.sv
module bwf_latency_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stage;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= 1'b0;
          else     stage[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= 1'b0;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage[DEPTH-1];

  // R1: reset clears the pipeline
  p_pipe_clear_r1: assert property (@(posedge clk) rst |=> !q_o);
endmodule

// File: rtl/bwf_event_gate.sv
module bwf_event_gate (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  input  logic win_i,
  input  logic blank_en_i,
  input  logic blank_inv_i,
  input  logic sync_en_i,
  output logic evt_o,
  output logic sync_o
);
  logic ev_q;
  logic rise;
  logic blocked;

  assign rise    = event_i & ~ev_q;
  assign blocked = blank_en_i & (blank_inv_i ? ~win_i : win_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= 1'b0;
      evt_o  <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      ev_q   <= event_i;
      evt_o  <= rise & ~blocked;
      sync_o <= rise & ~blocked & sync_en_i;
    end
  end

  // R5: one filtered pulse per rising edge
  p_one_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);

  // R9: sync request only with the enable sampled
  p_sync_gate_r9: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> ($past(sync_en_i) && evt_o));

  // R6: no pulse escapes an effective non-inverted window
  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> !$past(blank_en_i && !blank_inv_i && win_i));
endmodule

// File: rtl/blank_window_filter.sv
module blank_window_filter
  import bwf_pkg::*;
#(
  parameter int unsigned OFS_W = 16,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_zero_i,
  input  logic             ref_per_i,
  input  logic             ref_sel_i,
  input  logic             blank_en_i,
  input  logic             blank_inv_i,
  input  logic             sync_en_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [LEN_W-1:0] length_i,
  input  logic             event_i,
  output logic             evt_o,
  output logic             sync_o,
  output logic             win_o
);
  logic ref_pick;
  logic raw_win;

  assign ref_pick = ref_sel_i ? ref_per_i : ref_zero_i;

  bwf_win_timer #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .ref_i    (ref_pick),
    .offset_i (offset_i),
    .length_i (length_i),
    .raw_o    (raw_win)
  );

  bwf_latency_pipe #(.DEPTH(WIN_LATENCY)) u_lat (
    .clk (clk),
    .rst (rst),
    .d_i (raw_win),
    .q_o (win_o)
  );

  bwf_event_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .event_i     (event_i),
    .win_i       (win_o),
    .blank_en_i  (blank_en_i),
    .blank_inv_i (blank_inv_i),
    .sync_en_i   (sync_en_i),
    .evt_o       (evt_o),
    .sync_o      (sync_o)
  );

  // R1: outputs quiet on the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!evt_o && !sync_o && !win_o));
endmodule

// File: tb/blank_window_filter_tb_top.sv
module blank_window_filter_tb_top;
  localparam int OW = 16;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_zero_i = 1'b0, ref_per_i = 1'b0, ref_sel_i = 1'b0;
  logic          blank_en_i = 1'b0, blank_inv_i = 1'b0, sync_en_i = 1'b0;
  logic [OW-1:0] offset_i = '0;
  logic [LW-1:0] length_i = '0;
  logic          event_i = 1'b0;
  logic          evt_o, sync_o, win_o;

  always #5 clk = ~clk;

  blank_window_filter #(.OFS_W(OW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst), .ref_zero_i(ref_zero_i), .ref_per_i(ref_per_i),
    .ref_sel_i(ref_sel_i), .blank_en_i(blank_en_i), .blank_inv_i(blank_inv_i),
    .sync_en_i(sync_en_i), .offset_i(offset_i), .length_i(length_i),
    .event_i(event_i), .evt_o(evt_o), .sync_o(sync_o), .win_o(win_o)
  );

  typedef struct {
    logic  evt;
    logic  sync;
    logic  win;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // reference model state
  int   edge_no  = 0;
  bit   have_ref = 0;
  int   r_edge   = 0;
  int   m_off    = 0;
  int   m_len    = 0;
  logic hist [4];
  logic ev_prev  = 1'b0;

  // R-tagged step: drives inputs, predicts outputs after the coming edge
  task automatic step(input logic rs, input logic ev, input logic rz,
                      input logic rp, input string tag);
    exp_t e;
    logic sel_ref, raw_now, blocked, rise;
    @(negedge clk);
    rst = rs; event_i = ev; ref_zero_i = rz; ref_per_i = rp;
    if (rs) begin
      for (int i = 0; i < 4; i++) hist[i] = 1'b0;
      have_ref = 0; ev_prev = 1'b0;
      e.evt = 1'b0; e.sync = 1'b0; e.win = 1'b0;
    end else begin
      sel_ref = ref_sel_i ? rp : rz;
      if (sel_ref) begin
        have_ref = 1; r_edge = edge_no;
        m_off = int'(offset_i); m_len = int'(length_i);
      end
      raw_now = have_ref && (edge_no >= r_edge + m_off) &&
                (edge_no < r_edge + m_off + m_len);
      rise    = ev & ~ev_prev;
      blocked = blank_en_i & (blank_inv_i ? ~hist[3] : hist[3]);
      e.evt   = rise & ~blocked;
      e.sync  = e.evt & sync_en_i;
      e.win   = hist[2];
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = raw_now;
      ev_prev = ev;
    end
    e.tag = tag;
    exp_q.push_back(e);
    edge_no++;
    @(posedge clk);
  endtask

  // monitor: pops one expected item per edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (evt_o !== e.evt || sync_o !== e.sync || win_o !== e.win) begin
          n_fail++;
          $display("FAIL %s: evt/sync/win actual %b%b%b expected %b%b%b",
                   e.tag, evt_o, sync_o, win_o, e.evt, e.sync, e.win);
        end
      end
    end
  end

  task automatic toggles(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, i[0] == 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    idle(2, "R1");

    // R3/R6: non-inverted window, delay 2, length 4, sync on
    ref_sel_i = 0; blank_en_i = 1; blank_inv_i = 0; sync_en_i = 1;
    offset_i = 2; length_i = 4;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R3");
    toggles(14, "R6");
    idle(2, "R3");

    // R2: period strobe ignored when zero strobe selected
    step(1'b0, 1'b0, 1'b0, 1'b1, "R2");
    idle(8, "R2");
    // R2: period strobe selected
    ref_sel_i = 1;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
    idle(3, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R2");
    toggles(12, "R2");

    // R4: race just after the start, delay 0, length 6
    ref_sel_i = 0; offset_i = 0; length_i = 6;
    idle(3, "R4");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R4");
    toggles(14, "R4");

    // R7: inverted window
    blank_inv_i = 1; offset_i = 1; length_i = 5;
    idle(2, "R7");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
    toggles(16, "R7");
    blank_inv_i = 0;

    // R8: blanking disabled
    blank_en_i = 0;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R8");
    toggles(12, "R8");
    blank_en_i = 1;

    // R9: sync disabled
    sync_en_i = 0; offset_i = 0; length_i = 2;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
    toggles(12, "R9");
    sync_en_i = 1;

    // R5: level held high gives one pulse
    idle(2, "R5");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    idle(2, "R5");

    // R10: restart while delaying and while open
    offset_i = 3; length_i = 6;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R10");
    idle(2, "R10");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R10");
    toggles(8, "R10");
    offset_i = 0; length_i = 3;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R10");
    toggles(10, "R10");

    // R11: zero length blanks nothing
    offset_i = 0; length_i = 0;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R11");
    toggles(10, "R11");
    offset_i = 2;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R11");
    toggles(10, "R11");

    // R12: window spans the unselected strobe (period boundary)
    ref_sel_i = 1; offset_i = 6; length_i = 3;
    step(1'b0, 1'b0, 1'b0, 1'b1, "R12");
    idle(2, "R12");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R12");
    toggles(14, "R12");

    // R1: reset mid-window clears pipeline
    ref_sel_i = 0; offset_i = 0; length_i = 8;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R1");
    idle(4, "R1");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    idle(5, "R1");

    @(posedge clk); #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule